// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This block holds two down counters that both advance on the system clock, one count per cycle. Each channel has a reload register, a live count register, and two bits in a shared control word: a run bit and an auto-reload bit. When a running counter reaches zero, the next clock edge either reloads it from its reload register, which gives periodic operation, or stops it for good by clearing its own run bit, which gives one-shot operation. That same edge raises a latched cause bit for the channel.

A mask register chooses which cause bits drive the single level interrupt output. The output is registered. Channel 0 is normally programmed with all ones and auto-reload, and left masked, so that it runs as a free time base. Software turns it into a rising count by inverting what it reads. Channel 1 serves as the event source, in either one-shot or periodic mode.

Registers are reached over a single-cycle bus. A write request commits at the clock edge where it is presented. A read request returns its data on `bus_rdata` one cycle later.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: The control word sits at offset 0x000. Bit 0 runs channel 0, bit 1 is channel 0 auto-reload, bit 2 runs channel 1, and bit 3 is channel 1 auto-reload. All other bits read 0.
- R3: The reload and count registers are at 0x010 and 0x014 for channel 0, and at 0x018 and 0x01C for channel 1. Read data appears on `bus_rdata` the cycle after the request. Unmapped offsets read 0.
- R4: A running counter that is not at zero decreases by exactly 1 each cycle. A stopped counter holds its value.
- R5: With auto-reload set, a running counter at zero loads its reload value on the next edge and keeps running. A reload value of R therefore gives a period of R+1 cycles.
- R6: With auto-reload clear, a running counter at zero raises its cause bit once, clears its own run bit and holds at zero. It raises no further event until software rewrites it. A count of D written before the run bit is set puts the interrupt on `irq_o` D+2 cycles after the edge that sets the run bit.
- R7: A write to a count register takes effect on the next edge and overrides that cycle's decrement or reload.
- R8: The cause register is at 0x110, with channel 0 on bit 1 and channel 1 on bit 2. Writing 0 to a bit clears it and writing 1 leaves it unchanged. A channel event in the same cycle as a clear wins, so the bit stays set.
- R9: The mask register is at 0x114, with the same bit positions as the cause register. `irq_o` is the registered OR of cause AND mask, so it follows that value by one cycle.
- R10: A counter at zero with auto-reload and an all-ones reload value wraps to 0xFFFFFFFF. Its cause bit sets, but while its mask bit is clear `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counters advance on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access request, valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, registered, valid the cycle after a read request |
| irq_o | output | 1 | Level interrupt, registered |

## Verification
The bound checker watches, on every cycle, the per-channel next-state rules: single-step decrement, hold while stopped, reload on expiry, self-stop in one-shot mode, and count-register override. It also checks that an expiry always leaves its cause bit set, even against a clearing write, and that the interrupt tracks cause AND mask one cycle later. The address map, the bit positions, the end-to-end one-shot latency, the count sequence of a running periodic channel, the all-ones wrap and the absence of a second one-shot event can only be shown by the bench's scenarios, which read the registers through the bus.

// File: rtl/ttp_pkg.sv
package ttp_pkg;

  // Register offsets. The bus decoder and software both rely on these.
  localparam logic [11:0] OFS_CTRL     = 12'h000;
  localparam logic [11:0] OFS_RLD_BASE = 12'h010;
  localparam logic [11:0] OFS_VAL_BASE = 12'h014;
  localparam int          CH_STRIDE    = 8;
  localparam logic [11:0] OFS_CAUSE    = 12'h110;
  localparam logic [11:0] OFS_MASK     = 12'h114;

  // Position of channel 0 in the cause and mask words
  localparam int CAUSE_LSB = 1;

  typedef enum logic [2:0] {
    RS_NONE  = 3'd0,
    RS_CTRL  = 3'd1,
    RS_RLD   = 3'd2,
    RS_VAL   = 3'd3,
    RS_CAUSE = 3'd4,
    RS_MASK  = 3'd5
  } rsel_e;

endpackage

// File: rtl/ttp_decode.sv
module ttp_decode
  import ttp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ctrl_we,
  output logic [NUM_CH-1:0] rld_we,
  output logic [NUM_CH-1:0] val_we,
  output logic              cause_we,
  output logic              mask_we,
  output logic              rd_en,
  output rsel_e             rsel,
  output logic [CH_W-1:0]   rch
);

  logic wr_en;

  always_comb begin
    rsel = RS_NONE;
    rch  = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL))  rsel = RS_CTRL;
    if (bus_addr == ADDR_W'(OFS_CAUSE)) rsel = RS_CAUSE;
    if (bus_addr == ADDR_W'(OFS_MASK))  rsel = RS_MASK;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(int'(OFS_RLD_BASE) + CH_STRIDE * i)) begin
        rsel = RS_RLD;
        rch  = CH_W'(i);
      end
      if (bus_addr == ADDR_W'(int'(OFS_VAL_BASE) + CH_STRIDE * i)) begin
        rsel = RS_VAL;
        rch  = CH_W'(i);
      end
    end
  end

  assign wr_en    = bus_req & bus_wr;
  assign rd_en    = bus_req & ~bus_wr;
  assign ctrl_we  = wr_en && (rsel == RS_CTRL);
  assign cause_we = wr_en && (rsel == RS_CAUSE);
  assign mask_we  = wr_en && (rsel == RS_MASK);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_we
    assign rld_we[g] = wr_en && (rsel == RS_RLD) && (rch == CH_W'(g));
    assign val_we[g] = wr_en && (rsel == RS_VAL) && (rch == CH_W'(g));
  end

endmodule

// File: rtl/ttp_channel.sv
module ttp_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_we,
  input  logic             run_wd,
  input  logic             auto_wd,
  input  logic             rld_we,
  input  logic             val_we,
  input  logic [CNT_W-1:0] wdata,
  output logic             run,
  output logic             auto_rld,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reload,
  output logic             expire
);

  // A running counter sitting at zero expires on this edge
  assign expire = run && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
    end else if (rld_we) begin
      reload <= wdata;
    end
  end

  // Count register: a bus write beats reload and decrement
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (val_we) begin
      count <= wdata;
    end else if (expire) begin
      if (auto_rld) count <= reload;
    end else if (run) begin
      count <= count - 1'b1;
    end
  end

  // Control bits: a bus write beats the one-shot self-stop
  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      auto_rld <= 1'b0;
    end else if (ctrl_we) begin
      run      <= run_wd;
      auto_rld <= auto_wd;
    end else if (expire && !auto_rld) begin
      run      <= 1'b0;
    end
  end

endmodule

// File: rtl/ttp_intc.sv
module ttp_intc #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] expire,
  input  logic              cause_we,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] cause,
  output logic [NUM_CH-1:0] mask,
  output logic              irq
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        cause[g] <= 1'b0;
      end else if (expire[g]) begin
        cause[g] <= 1'b1;
      end else if (cause_we && !wbits[g]) begin
        cause[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask[g] <= 1'b0;
      end else if (mask_we) begin
        mask[g] <= wbits[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(cause & mask);
  end

endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import ttp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);

  localparam int NUM_CH = 2;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic                         ctrl_we, cause_we, mask_we, rd_en;
  logic [NUM_CH-1:0]            rld_we, val_we;
  rsel_e                        rsel;
  logic [CH_W-1:0]              rch;
  logic [NUM_CH-1:0]            ch_run, ch_auto, ch_expire;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_count, ch_reload;
  logic [NUM_CH-1:0]            cause, mask, src_wbits;
  logic [CNT_W-1:0]             ctrl_word, cause_word, mask_word, rd_word;

  ttp_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_decode (
    .bus_req (bus_req),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .ctrl_we (ctrl_we),
    .rld_we  (rld_we),
    .val_we  (val_we),
    .cause_we(cause_we),
    .mask_we (mask_we),
    .rd_en   (rd_en),
    .rsel    (rsel),
    .rch     (rch)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ttp_channel #(.CNT_W(CNT_W)) u_channel (
      .clk     (clk),
      .rst     (rst),
      .ctrl_we (ctrl_we),
      .run_wd  (bus_wdata[2*g]),
      .auto_wd (bus_wdata[2*g+1]),
      .rld_we  (rld_we[g]),
      .val_we  (val_we[g]),
      .wdata   (bus_wdata),
      .run     (ch_run[g]),
      .auto_rld(ch_auto[g]),
      .count   (ch_count[g]),
      .reload  (ch_reload[g]),
      .expire  (ch_expire[g])
    );
    assign src_wbits[g] = bus_wdata[CAUSE_LSB+g];
  end

  ttp_intc #(.NUM_CH(NUM_CH)) u_intc (
    .clk     (clk),
    .rst     (rst),
    .expire  (ch_expire),
    .cause_we(cause_we),
    .mask_we (mask_we),
    .wbits   (src_wbits),
    .cause   (cause),
    .mask    (mask),
    .irq     (irq_o)
  );

  // Pack the status words in their software-visible positions
  always_comb begin
    ctrl_word  = '0;
    cause_word = '0;
    mask_word  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      ctrl_word[2*i]           = ch_run[i];
      ctrl_word[2*i+1]         = ch_auto[i];
      cause_word[CAUSE_LSB+i]  = cause[i];
      mask_word[CAUSE_LSB+i]   = mask[i];
    end
  end

  always_comb begin
    case (rsel)
      RS_CTRL:  rd_word = ctrl_word;
      RS_RLD:   rd_word = ch_reload[rch];
      RS_VAL:   rd_word = ch_count[rch];
      RS_CAUSE: rd_word = cause_word;
      RS_MASK:  rd_word = mask_word;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_word;
  end

endmodule

// File: rtl/ttp_checker.sv
module ttp_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_CH-1:0]            ch_run,
  input logic [NUM_CH-1:0]            ch_auto,
  input logic [NUM_CH-1:0]            ch_expire,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_count,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_reload,
  input logic [NUM_CH-1:0]            val_we,
  input logic                         ctrl_we,
  input logic [CNT_W-1:0]             bus_wdata,
  input logic [NUM_CH-1:0]            cause,
  input logic [NUM_CH-1:0]            mask,
  input logic                         irq_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_run[g] && ch_count[g] != '0 && !val_we[g]) |=> ch_count[g] == $past(ch_count[g]) - 1'b1);

    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (rst)
      (!ch_run[g] && !val_we[g]) |=> $stable(ch_count[g]));

    p_reload_r5: assert property (@(posedge clk) disable iff (rst)
      (ch_expire[g] && ch_auto[g] && !val_we[g]) |=> ch_count[g] == $past(ch_reload[g]));

    p_self_stop_r6: assert property (@(posedge clk) disable iff (rst)
      (ch_expire[g] && !ch_auto[g] && !ctrl_we) |=> !ch_run[g]);

    p_value_override_r7: assert property (@(posedge clk) disable iff (rst)
      val_we[g] |=> ch_count[g] == $past(bus_wdata));

    p_cause_set_r8: assert property (@(posedge clk) disable iff (rst)
      ch_expire[g] |=> cause[g]);
  end

  p_irq_high_r9: assert property (@(posedge clk) disable iff (rst)
    ((cause & mask) != '0) |=> irq_o);

  p_irq_low_r9: assert property (@(posedge clk) disable iff (rst)
    ((cause & mask) == '0) |=> !irq_o);

endmodule

bind tick_timer_pair ttp_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_ttp_checker (
  .clk      (clk),
  .rst      (rst),
  .ch_run   (ch_run),
  .ch_auto  (ch_auto),
  .ch_expire(ch_expire),
  .ch_count (ch_count),
  .ch_reload(ch_reload),
  .val_we   (val_we),
  .ctrl_we  (ctrl_we),
  .bus_wdata(bus_wdata),
  .cause    (cause),
  .mask     (mask),
  .irq_o    (irq_o)
);

// File: tb/test_tick_timer_pair.sv
`timescale 1ns/1ps
module test_tick_timer_pair;

  localparam int ADDR_W = 12;
  localparam int CNT_W  = 32;

  localparam logic [11:0] A_CTRL  = 12'h000;
  localparam logic [11:0] A_RLD0  = 12'h010;
  localparam logic [11:0] A_VAL0  = 12'h014;
  localparam logic [11:0] A_RLD1  = 12'h018;
  localparam logic [11:0] A_VAL1  = 12'h01C;
  localparam logic [11:0] A_CAUSE = 12'h110;
  localparam logic [11:0] A_MASK  = 12'h114;

  typedef struct packed {
    logic        wr;
    logic [3:0]  req;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // Register map vectors, all with both channels stopped (R2, R3, R8, R9)
  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 4'd2, A_CTRL,  32'hFFFF_FFFA, 32'h0},
    '{1'b0, 4'd2, A_CTRL,  32'h0,         32'h0000_000A},
    '{1'b1, 4'd3, A_RLD0,  32'hDEAD_BEEF, 32'h0},
    '{1'b0, 4'd3, A_RLD0,  32'h0,         32'hDEAD_BEEF},
    '{1'b1, 4'd3, A_RLD1,  32'h0000_1234, 32'h0},
    '{1'b0, 4'd3, A_RLD1,  32'h0,         32'h0000_1234},
    '{1'b1, 4'd3, A_VAL0,  32'h0000_55AA, 32'h0},
    '{1'b0, 4'd3, A_VAL0,  32'h0,         32'h0000_55AA},
    '{1'b1, 4'd3, A_VAL1,  32'h0000_0077, 32'h0},
    '{1'b0, 4'd3, A_VAL1,  32'h0,         32'h0000_0077},
    '{1'b1, 4'd9, A_MASK,  32'hFFFF_FFFF, 32'h0},
    '{1'b0, 4'd9, A_MASK,  32'h0,         32'h0000_0006},
    '{1'b1, 4'd9, A_MASK,  32'h0,         32'h0},
    '{1'b0, 4'd9, A_MASK,  32'h0,         32'h0},
    '{1'b0, 4'd8, A_CAUSE, 32'h0,         32'h0},
    '{1'b1, 4'd2, A_CTRL,  32'h0,         32'h0},
    '{1'b0, 4'd2, A_CTRL,  32'h0,         32'h0},
    '{1'b0, 4'd3, 12'h004, 32'h0,         32'h0}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_req;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [CNT_W-1:0]  bus_wdata;
  logic [CNT_W-1:0]  bus_rdata;
  logic              irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic done   = 1'b0;

  always #2 clk = ~clk;

  tick_timer_pair #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_tick_timer_pair (
    .clk      (clk),
    .rst      (rst),
    .bus_req  (bus_req),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Each task is entered at a falling edge and returns at a falling edge
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, rd2;
    int          first_irq;

    rst = 1'b1; bus_req = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    bus_read(A_CTRL, rd);  check("R1 ctrl",  rd, 32'h0);
    bus_read(A_RLD0, rd);  check("R1 rld0",  rd, 32'h0);
    bus_read(A_VAL1, rd);  check("R1 val1",  rd, 32'h0);
    bus_read(A_CAUSE, rd); check("R1 cause", rd, 32'h0);
    bus_read(A_MASK, rd);  check("R1 mask",  rd, 32'h0);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].data);
      else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, VECS[i].exp);
      end
    end

    // R4: running counter drops by one per cycle; reads 11 edges apart
    bus_write(A_VAL0, 32'd1000);
    bus_write(A_CTRL, 32'h1);
    bus_read(A_VAL0, rd);
    check("R4 first sample", rd, 32'd1000);
    repeat (10) @(negedge clk);
    bus_read(A_VAL0, rd2);
    check("R4 decrement per cycle", rd - rd2, 32'd11);

    // R7: count write overrides the decrement
    bus_write(A_VAL0, 32'd5000);
    bus_read(A_VAL0, rd);
    check("R7 value override", rd, 32'd5000);

    // R4: stopped counter holds
    bus_write(A_CTRL, 32'h0);
    bus_read(A_VAL0, rd);
    repeat (5) @(negedge clk);
    bus_read(A_VAL0, rd2);
    check("R4 hold when stopped", rd2, rd);

    // R6 + R9: one-shot on channel 1, count 5, irq at 5+2 cycles
    bus_write(A_MASK, 32'h4);
    bus_write(A_VAL1, 32'd5);
    bus_write(A_CTRL, 32'h4);
    first_irq = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (irq_o && first_irq == 0) first_irq = k;
    end
    check("R6 one-shot irq latency", first_irq, 32'd7);
    bus_read(A_CTRL, rd);  check("R6 run bit self-cleared", rd, 32'h0);
    bus_read(A_VAL1, rd);  check("R6 holds at zero", rd, 32'h0);
    bus_read(A_CAUSE, rd); check("R8 cause bit 2 set", rd, 32'h4);

    // R8: writing 1 keeps, writing 0 clears; R9 irq follows one cycle later
    bus_write(A_CAUSE, 32'hFFFF_FFFF);
    bus_read(A_CAUSE, rd); check("R8 write one keeps", rd, 32'h4);
    bus_write(A_CAUSE, 32'h0);
    check("R9 irq still high right after clear", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    check("R9 irq drops one cycle after clear", {31'b0, irq_o}, 32'h0);
    bus_read(A_CAUSE, rd); check("R8 cleared", rd, 32'h0);
    repeat (20) @(negedge clk);
    bus_read(A_CAUSE, rd); check("R6 no second event", rd, 32'h0);
    check("R6 irq stays low", {31'b0, irq_o}, 32'h0);

    // R5: periodic channel 1, reload 3 -> sequence 3,2,1,0,3,...
    bus_write(A_RLD1, 32'd3);
    bus_write(A_VAL1, 32'd3);
    bus_write(A_CTRL, 32'hC);
    for (int k = 0; k < 8; k++) begin
      bus_read(A_VAL1, rd);
      check($sformatf("R5 periodic step %0d", k), rd, 32'd3 - 32'(k % 4));
    end
    bus_read(A_CTRL, rd); check("R5 keeps running", rd, 32'hC);

    // R8: reload 0 expires every cycle, so a clear always loses
    bus_write(A_RLD1, 32'd0);
    bus_write(A_VAL1, 32'd0);
    repeat (2) @(negedge clk);
    bus_write(A_CAUSE, 32'h0);
    bus_read(A_CAUSE, rd); check("R8 set beats clear", rd, 32'h4);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_CAUSE, 32'h0);
    bus_write(A_MASK, 32'h0);
    repeat (2) @(negedge clk);
    check("R9 irq low with mask clear", {31'b0, irq_o}, 32'h0);

    // R10: all-ones wrap on channel 0, masked
    bus_write(A_RLD0, 32'hFFFF_FFFF);
    bus_write(A_VAL0, 32'd2);
    bus_write(A_CTRL, 32'h3);
    bus_read(A_VAL0, rd); check("R10 step 0", rd, 32'd2);
    bus_read(A_VAL0, rd); check("R10 step 1", rd, 32'd1);
    bus_read(A_VAL0, rd); check("R10 step 2", rd, 32'd0);
    bus_read(A_VAL0, rd); check("R10 wraps to all ones", rd, 32'hFFFF_FFFF);
    bus_read(A_VAL0, rd); check("R10 continues down", rd, 32'hFFFF_FFFE);
    bus_read(A_CAUSE, rd); check("R10 cause bit 1 set", rd, 32'h2);
    @(negedge clk);
    check("R10 masked channel no irq", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule